// File: doc/BRIEF.md
# Sampled Input Glitch Qualifier

This block cleans up asynchronous pins before a capture unit sees them. Every pin first passes through a two-stage synchronizer. A group-wide divider then produces a sample strobe, and on each strobe every pin shifts its synchronized level into a short history. A qualified pin moves its output to a new level only when every sample in its window holds that level. If the samples disagree, the output keeps its last value. Short spikes therefore never reach the capture logic.

Eight pins share one 8-bit period setting. The spacing between strobes is twice that setting in clock cycles, and a setting of zero samples on every cycle. Each pin has its own 2-bit mode. The mode selects one of four paths: the synchronizer alone, a three-sample window, a six-sample window, or a direct path from the pin to the output that uses no clock.

Top module: `qual_group`

## Requirements
- R1: While reset is high, all synchronizer stages, sample histories and qualified levels clear to 0. On the first falling edge after a reset edge, every pin in modes 0, 1 or 2 outputs 0.
- R2: In mode 0 (2'b00), a pin's output equals its input as sampled two rising edges earlier.
- R3: In mode 3 (2'b11), a pin's output follows its input with no clock involved, including while reset is high.
- R4: The sample strobe fires every 2×P clock cycles, where P is the period setting. When P = 0 it fires every cycle. The first strobe after reset comes on the 2×P-th rising edge.
- R5: In mode 1 (2'b01), on a strobe edge the output takes level L when the three most recent synchronized samples, counting the one taken on that edge, are all L.
- R6: In mode 2 (2'b10), the same rule applies over the six most recent samples. In modes 1 and 2 the output changes on no edge other than a strobe edge.
- R7: A pulse that yields fewer samples than the window leaves the output at its previous level.
- R8: All eight pins share one strobe. Each pin's mode field sits at bits [2i+1:2i] of the mode bus and affects only pin i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| qual_period | input | 8 | Shared period setting P; strobe spacing is 2×P cycles |
| pin_mode | input | 16 | Per-pin mode, 2 bits per pin, pin i at [2i+1:2i] |
| pin_in | input | 8 | Raw asynchronous pin levels |
| pin_out | output | 8 | Qualified pin levels |

## Verification
Each output has its own latency. The bypass output is due in the same cycle as its input. The mode-0 output is due two rising edges after its input. A windowed output is due on the rising edge whose strobe completes the window, which is two synchronizer edges and then N strobes after a steady input. The bench drives inputs on falling edges and advances a cycle model of its own on every rising edge. It compares all eight outputs on the next falling edge, before it drives new inputs, so every output is read half a cycle after the edge that made it. Separate pulse tests use inputs sized to fill all but one sample of each window.

// File: rtl/qual_pkg.sv
package qual_pkg;

    typedef enum logic [1:0] {
        QM_SYNC   = 2'd0,
        QM_WIN3   = 2'd1,
        QM_WIN6   = 2'd2,
        QM_BYPASS = 2'd3
    } qmode_e;

    localparam int SYNC_DEPTH = 2;
    localparam int WIN_SHORT  = 3;
    localparam int WIN_LONG   = 6;

    // history of samples plus the qualified level of one pin
    typedef struct packed {
        logic [WIN_LONG-1:0] hist;
        logic                level;
    } qual_state_t;

    function automatic int unsigned win_len(qmode_e m);
        return (m == QM_WIN3) ? WIN_SHORT : WIN_LONG;
    endfunction

    function automatic logic [WIN_LONG-1:0] win_mask(int unsigned n);
        logic [WIN_LONG-1:0] msk;
        msk = '0;
        for (int k = 0; k < WIN_LONG; k++) begin
            if (k < int'(n)) msk[k] = 1'b1;
        end
        return msk;
    endfunction

    function automatic logic is_windowed(qmode_e m);
        return (m == QM_WIN3) || (m == QM_WIN6);
    endfunction

endpackage

// File: rtl/qual_period_div.sv
module qual_period_div #(
    parameter int PERIOD_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [PERIOD_W-1:0] period,
    output logic                tick
);
    localparam int CNT_W = PERIOD_W + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;

    always_comb begin
        lim  = {period, 1'b0} - CNT_W'(1);
        tick = (period == '0) || (cnt >= lim);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/qual_sync.sv
module qual_sync #(
    parameter int DEPTH = qual_pkg::SYNC_DEPTH
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [DEPTH-1:0] stage_q;

    generate
        if (DEPTH == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) stage_q <= '0;
                else     stage_q <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) stage_q <= '0;
                else     stage_q <= {stage_q[DEPTH-2:0], din};
            end
        end
    endgenerate

    assign dout = stage_q[DEPTH-1];
endmodule

// File: rtl/qual_pin.sv
module qual_pin
    import qual_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  qmode_e mode,
    input  logic   din,
    output logic   dout
);
    logic        synced;
    qual_state_t st_q, st_n;
    logic [WIN_LONG-1:0] msk;

    qual_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (din),
        .dout (synced)
    );

    always_comb begin
        st_n = st_q;
        msk  = win_mask(win_len(mode));
        if (tick) begin
            st_n.hist = {st_q.hist[WIN_LONG-2:0], synced};
            if (is_windowed(mode)) begin
                if ((st_n.hist & msk) == msk) begin
                    st_n.level = 1'b1;
                end else if ((st_n.hist & msk) == '0) begin
                    st_n.level = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_n;
    end

    always_comb begin
        unique case (mode)
            QM_SYNC:   dout = synced;
            QM_WIN3,
            QM_WIN6:   dout = st_q.level;
            QM_BYPASS: dout = din;
            default:   dout = synced;
        endcase
    end
endmodule

// File: rtl/qual_group.sv
module qual_group
    import qual_pkg::*;
#(
    parameter int NPINS    = 8,
    parameter int PERIOD_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [PERIOD_W-1:0]   qual_period,
    input  logic [2*NPINS-1:0]    pin_mode,
    input  logic [NPINS-1:0]      pin_in,
    output logic [NPINS-1:0]      pin_out
);
    logic samp_tick;

    qual_period_div #(.PERIOD_W(PERIOD_W)) u_div (
        .clk    (clk),
        .rst    (rst),
        .period (qual_period),
        .tick   (samp_tick)
    );

    generate
        for (genvar i = 0; i < NPINS; i++) begin : g_pin
            qual_pin u_pin (
                .clk  (clk),
                .rst  (rst),
                .tick (samp_tick),
                .mode (qmode_e'(pin_mode[2*i +: 2])),
                .din  (pin_in[i]),
                .dout (pin_out[i])
            );
        end
    endgenerate
endmodule

// File: rtl/qual_group_chk.sv
module qual_group_chk #(
    parameter int NPINS    = 8,
    parameter int PERIOD_W = 8
) (
    input logic                clk,
    input logic                rst,
    input logic [PERIOD_W-1:0] qual_period,
    input logic [2*NPINS-1:0]  pin_mode,
    input logic [NPINS-1:0]    pin_in,
    input logic [NPINS-1:0]    pin_out,
    input logic                samp_tick
);
    localparam int GAP_W = PERIOD_W + 2;

    logic [GAP_W-1:0]    gap;
    logic                seen;
    logic [PERIOD_W-1:0] per_q;

    always_ff @(posedge clk) begin
        per_q <= qual_period;
        if (rst || (qual_period != per_q)) begin
            gap  <= '0;
            seen <= 1'b0;
        end else if (samp_tick) begin
            gap  <= GAP_W'(1);
            seen <= 1'b1;
        end else begin
            gap  <= gap + GAP_W'(1);
        end
    end

    // R4
    strobe_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (samp_tick && seen && qual_period == per_q) |->
        (gap == ((qual_period == '0) ? GAP_W'(1) : {1'b0, qual_period, 1'b0})));

    generate
        for (genvar i = 0; i < NPINS; i++) begin : g_c
            logic [1:0] md;
            assign md = pin_mode[2*i +: 2];

            // R1
            reset_clear_chk: assert property (@(posedge clk)
                (rst && md != 2'd3) |=> (md == 2'd3 || pin_out[i] == 1'b0));

            // R2
            sync_delay_chk: assert property (@(posedge clk) disable iff (rst)
                (md == 2'd0 && !$past(rst) && !$past(rst, 2)) |->
                (pin_out[i] == $past(pin_in[i], 2)));

            // R3
            bypass_path_chk: assert property (@(posedge clk)
                (md == 2'd3) |-> (pin_out[i] == pin_in[i]));

            // R6 (also R5): windowed outputs move only on strobe edges
            strobe_only_chk: assert property (@(posedge clk) disable iff (rst)
                ((md == 2'd1 || md == 2'd2) && $past(md) == md && !$past(rst)
                 && pin_out[i] != $past(pin_out[i])) |-> $past(samp_tick));
        end
    endgenerate
endmodule

bind qual_group qual_group_chk #(.NPINS(NPINS), .PERIOD_W(PERIOD_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .qual_period (qual_period),
    .pin_mode    (pin_mode),
    .pin_in      (pin_in),
    .pin_out     (pin_out),
    .samp_tick   (samp_tick)
);

// File: tb/sim_qual_group.sv
`timescale 1ns/1ps
module sim_qual_group;
    localparam int NP = 8;
    localparam int PW = 8;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [PW-1:0]  per = '0;
    logic [2*NP-1:0] modes = '0;
    logic [NP-1:0]  pin = '0;
    logic [NP-1:0]  pout;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    qual_group #(.NPINS(NP), .PERIOD_W(PW)) u0 (
        .clk         (clk),
        .rst         (rst),
        .qual_period (per),
        .pin_mode    (modes),
        .pin_in      (pin),
        .pin_out     (pout)
    );

    // cycle model built from the requirements
    int          m_el;
    logic        m_tk;
    logic [1:0]  m_md;
    logic [NP-1:0] m_s1, m_s2, m_q;
    logic [5:0]  m_sh [NP];

    always @(posedge clk) begin
        if (rst) begin
            m_el = 0; m_s1 = '0; m_s2 = '0; m_q = '0;
            for (int i = 0; i < NP; i++) m_sh[i] = '0;
        end else begin
            m_tk = (per == 0) || (m_el + 1 >= 2 * int'(per));
            m_el = m_tk ? 0 : m_el + 1;
            for (int i = 0; i < NP; i++) begin
                if (m_tk) begin
                    m_sh[i] = {m_sh[i][4:0], m_s2[i]};
                    m_md = modes[2*i +: 2];
                    if (m_md == 2'd1) begin
                        if (m_sh[i][2:0] == 3'b111) m_q[i] = 1'b1;
                        else if (m_sh[i][2:0] == 3'b000) m_q[i] = 1'b0;
                    end else if (m_md == 2'd2) begin
                        if (m_sh[i] == 6'b111111) m_q[i] = 1'b1;
                        else if (m_sh[i] == 6'b000000) m_q[i] = 1'b0;
                    end
                end
            end
            m_s2 = m_s1;
            m_s1 = pin;
        end
    end

    task automatic chk(string req, int idx, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s pin %0d: actual %b expected %b", req, idx, act, exp);
        end
    endtask

    task automatic check_all();
        for (int i = 0; i < NP; i++) begin
            case (modes[2*i +: 2])
                2'd0: chk("R2 R8", i, pout[i], m_s2[i]);
                2'd1: chk("R5 R4 R8", i, pout[i], m_q[i]);
                2'd2: chk("R6 R4 R8", i, pout[i], m_q[i]);
                default: chk("R3 R8", i, pout[i], pin[i]);
            endcase
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // pulse of 'hi' cycles on all pins, then low; output must stay 0
    task automatic pulse_test(string req, logic [2*NP-1:0] md, int hi, int settle);
        per = 8'd1; modes = md; pin = '0;
        do_reset();
        pin = '1;
        repeat (hi) begin
            @(negedge clk);
            for (int i = 0; i < NP; i++) chk(req, i, pout[i], 1'b0);
        end
        pin = '0;
        repeat (20) begin
            @(negedge clk);
            for (int i = 0; i < NP; i++) chk(req, i, pout[i], 1'b0);
        end
        pin = '1;
        repeat (settle) @(negedge clk);
        for (int i = 0; i < NP; i++) chk(req, i, pout[i], 1'b1);
    endtask

    initial begin
        logic [15:0] lfsr;
        int          pers [5];
        pers = '{0, 1, 2, 5, 255};
        lfsr = 16'hACE1;

        // R1: reset clears; R3 bypass works during reset
        per = 8'd3; modes = 16'hE4E4; pin = '1; rst = 1'b1;
        repeat (3) @(negedge clk);
        for (int i = 0; i < NP; i++) begin
            if (modes[2*i +: 2] == 2'd3) chk("R3", i, pout[i], 1'b1);
            else                          chk("R1", i, pout[i], 1'b0);
        end

        // R7: six-sample window, 10 high cycles give only 5 samples
        pulse_test("R7 R6", 16'hAAAA, 10, 20);
        // R7: three-sample window, 4 high cycles give only 2 samples
        pulse_test("R7 R5", 16'h5555, 4, 12);

        // sweeps: every pin through every mode at several periods
        foreach (pers[p]) begin
            for (int r = 0; r < 4; r++) begin
                int ncyc;
                per = PW'(pers[p]);
                for (int i = 0; i < NP; i++) modes[2*i +: 2] = 2'((i + r) % 4);
                pin = '0;
                do_reset();
                ncyc = (pers[p] >= 64) ? 3000 : 1200;
                for (int c = 0; c < ncyc; c++) begin
                    @(negedge clk);
                    check_all();
                    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                    if (c % (2 * pers[p] + 1) == 0)
                        pin = pin ^ (lfsr[7:0] & lfsr[15:8] & {lfsr[11:8], lfsr[3:0]});
                end
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule